// File: doc/BRIEF.md
# Serial NOR Single-Byte Read Engine

This block fetches one byte from a serial NOR flash. Software loads a read opcode, a 32-bit address split over four byte registers, a lane mode and an options byte. It then writes the start code 0x81 to the command register. The engine selects the flash and shifts the opcode and the address out on IO0. It inserts dummy clocks where the chosen read form needs them and gathers the eight data bits over one, two or four IO lines. It then deselects the flash and leaves the byte in a read-data register. The hardware clears the low start bits of the command register when the read is done, so software polls the command register until those bits read zero.

The register port is byte wide. A write strobe with an address and data updates a register on the clock edge. The read side is a plain combinational mux selected by a separate read address. The flash side is driven in SPI mode 0: the serial clock idles low, the engine changes its outputs on the falling edge and samples the IO lines on the rising edge. The serial clock half-period is a fixed number of system clocks set by a parameter.

Sequencer states and transitions:
- `S_IDLE` goes to `S_OPC` on a valid start.
- `S_OPC` goes to `S_ADDR` after 8 clocks.
- `S_ADDR` goes to `S_DUMMY` after 24 or 32 clocks if dummy clocks are needed, and to `S_DATA` otherwise.
- `S_DUMMY` goes to `S_DATA` after 8 clocks.
- `S_DATA` goes to `S_FINISH` after 8, 4 or 2 clocks. Chip select is released on this transition.
- `S_FINISH` returns to `S_IDLE` after one system clock. On that edge the byte is stored and the start bits are cleared.

Top module: `nor_byte_reader`

Register map (4-bit register address):

| Address | Register |
|---|---|
| 0 | Command |
| 1 | Address bits 7:0 |
| 2 | Address bits 15:8 |
| 3 | Address bits 23:16 |
| 4 | Address bits 31:24 |
| 5 | Read opcode |
| 6 | Lane mode |
| 7 | Options: bit 0 fast form, bit 1 four-byte address |
| 8 | Read data (read only) |

## Requirements
- R1: After reset, chip select is high, the serial clock is low, no IO line is driven, and the command register and the read-data register both read 0x00.
- R2: Writing 0x81 to the command register (address 0) while idle starts one read, and the command register then reads 0x81. When the read completes, the low five bits of the code are cleared and the command register reads 0x80. Writing any other value to the command register while idle starts nothing and leaves the register unchanged.
- R3: The opcode held at register address 5 is sent first, as 8 clocks on IO0, most significant bit first. IO0 is the only line the engine ever drives, and it is driven only during the opcode and address phases.
- R4: The address is made from address 4 (bits 31:24) down to address 1 (bits 7:0). Only bits 23:0 are sent, MSB first on IO0, unless options bit 1 is set, in which case all 32 bits are sent.
- R5: Eight dummy clocks follow the address when options bit 0 is set, or when the lane mode is dual or quad. A plain single-lane read with options bit 0 clear has no dummy clocks.
- R6: The lane mode at address 6 sets how the data arrives. The value 0x00 selects single lane: one bit per clock on IO1, 8 clocks. The value 0x01 selects dual: two bits per clock as {IO1,IO0}, 4 clocks. The value 0x04 selects quad: four bits per clock as {IO3..IO0}, 2 clocks. Data is most significant bits first.
- R7: The received byte reads back from address 8 once the command start bits have cleared.
- R8: Chip select rises on the edge after the last data bit is sampled. The command start bits read as cleared from the very next system clock edge.
- R9: A write to the command register during a read is ignored. The command register keeps 0x81 and the read completes with correct data.
- R10: The serial clock is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write address |
| reg_wdata | input | 8 | Register write data |
| reg_raddr | input | 4 | Register read address |
| reg_rdata | output | 8 | Register read data (combinational) |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sck | output | 1 | Flash serial clock |
| flash_io_o | output | 4 | Flash IO output values |
| flash_io_oe | output | 4 | Flash IO output enables |
| flash_io_i | input | 4 | Flash IO input values |

## Verification
With the default half-period of 2 system clocks, one serial clock lasts 4 system clocks. A read finishes 4 × (8 + address bits + dummy + data clocks) system clocks after the start plus a few cycles of setup and release. The bench therefore never predicts a completion cycle. It polls the command register until the start bits clear, and only then compares the opcode, address and clock count seen by its flash model and the read-data register. The one exact timing check, R8, samples on the falling system edge. It looks for the first sample with chip select high, expects the start bits still set there, and expects them cleared one system clock later. Register writes are applied on falling edges, and a read-back is sampled just after the read address is set.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
    localparam logic [7:0] START_CODE = 8'h81;
    localparam logic [4:0] START_LOW  = START_CODE[4:0];

    localparam logic [3:0] RA_CMD   = 4'd0;
    localparam logic [3:0] RA_ADR0  = 4'd1;
    localparam logic [3:0] RA_ADR1  = 4'd2;
    localparam logic [3:0] RA_ADR2  = 4'd3;
    localparam logic [3:0] RA_ADR3  = 4'd4;
    localparam logic [3:0] RA_OPC   = 4'd5;
    localparam logic [3:0] RA_MODE  = 4'd6;
    localparam logic [3:0] RA_OPT   = 4'd7;
    localparam logic [3:0] RA_RDATA = 4'd8;

    localparam int ADDR_W    = 32;
    localparam int DUMMY_CLK = 8;

    typedef enum logic [2:0] {
        S_IDLE, S_OPC, S_ADDR, S_DUMMY, S_DATA, S_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        W_ONE, W_TWO, W_FOUR
    } lane_t;
endpackage

// File: rtl/nbr_regs.sv
module nbr_regs
    import nbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [3:0]  waddr,
    input  logic [7:0]  wdata,
    input  logic [3:0]  raddr,
    output logic [7:0]  rdata,
    input  logic        done,
    input  logic [7:0]  rx_byte,
    output logic        start,
    output logic        busy,
    output logic [7:0]  opcode,
    output logic [ADDR_W-1:0] addr,
    output lane_t       lane,
    output logic        fast,
    output logic        four_byte
);
    logic [7:0] cmd_q, mode_q, opt_q, rd_q;
    logic [7:0] adr_q [4];

    assign busy  = |cmd_q[4:0];
    assign start = we && (waddr == RA_CMD) && (wdata == START_CODE) && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            mode_q <= '0;
            opt_q  <= '0;
            opcode <= '0;
            rd_q   <= '0;
            for (int i = 0; i < 4; i++) adr_q[i] <= '0;
        end else begin
            if (start)
                cmd_q <= wdata;
            else if (done)
                cmd_q <= cmd_q & ~{3'b000, START_LOW};
            if (done)
                rd_q <= rx_byte;
            if (we) begin
                unique case (waddr)
                    RA_ADR0: adr_q[0] <= wdata;
                    RA_ADR1: adr_q[1] <= wdata;
                    RA_ADR2: adr_q[2] <= wdata;
                    RA_ADR3: adr_q[3] <= wdata;
                    RA_OPC:  opcode   <= wdata;
                    RA_MODE: mode_q   <= wdata;
                    RA_OPT:  opt_q    <= wdata;
                    default: ;
                endcase
            end
        end
    end

    assign addr      = {adr_q[3], adr_q[2], adr_q[1], adr_q[0]};
    assign fast      = opt_q[0];
    assign four_byte = opt_q[1];

    always_comb begin
        if (mode_q == 8'h01)      lane = W_TWO;
        else if (mode_q == 8'h04) lane = W_FOUR;
        else                      lane = W_ONE;
    end

    always_comb begin
        unique case (raddr)
            RA_CMD:   rdata = cmd_q;
            RA_ADR0:  rdata = adr_q[0];
            RA_ADR1:  rdata = adr_q[1];
            RA_ADR2:  rdata = adr_q[2];
            RA_ADR3:  rdata = adr_q[3];
            RA_OPC:   rdata = opcode;
            RA_MODE:  rdata = mode_q;
            RA_OPT:   rdata = opt_q;
            RA_RDATA: rdata = rd_q;
            default:  rdata = '0;
        endcase
    end

    // R2: an accepted start code makes the engine busy on the next edge
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/nbr_tick.sv
module nbr_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/nbr_seq.sv
module nbr_seq
    import nbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        tick,
    input  logic [7:0]  opcode,
    input  logic [ADDR_W-1:0] addr,
    input  lane_t       lane,
    input  logic        fast,
    input  logic        four_byte,
    input  logic [3:0]  io_i,
    output logic        run,
    output logic        cs_n,
    output logic        sck,
    output logic [3:0]  io_o,
    output logic [3:0]  io_oe,
    output logic [7:0]  rx_byte,
    output logic        done
);
    seq_state_t state_q, state_d;
    logic [ADDR_W-1:0] sh_q, adr_q;
    logic [4:0]  cnt_q;
    lane_t       lane_q;
    logic        dummy_q, four_q;
    logic        rise, fall, last;
    logic [4:0]  data_cnt;

    assign rise = tick && !sck;
    assign fall = tick && sck;
    assign last = fall && (cnt_q == 5'd0);

    always_comb begin
        unique case (lane_q)
            W_TWO:   data_cnt = 5'd3;
            W_FOUR:  data_cnt = 5'd1;
            default: data_cnt = 5'd7;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_OPC;
            S_OPC:    if (last)  state_d = S_ADDR;
            S_ADDR:   if (last)  state_d = dummy_q ? S_DUMMY : S_DATA;
            S_DUMMY:  if (last)  state_d = S_DATA;
            S_DATA:   if (last)  state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n    <= 1'b1;
            sck     <= 1'b0;
            sh_q    <= '0;
            adr_q   <= '0;
            cnt_q   <= '0;
            lane_q  <= W_ONE;
            dummy_q <= 1'b0;
            four_q  <= 1'b0;
            rx_byte <= '0;
        end else if (state_q == S_IDLE) begin
            if (start) begin
                cs_n    <= 1'b0;
                sh_q    <= {opcode, {(ADDR_W-8){1'b0}}};
                adr_q   <= addr;
                cnt_q   <= 5'd7;
                lane_q  <= lane;
                dummy_q <= fast || (lane != W_ONE);
                four_q  <= four_byte;
            end
        end else if (rise) begin
            sck <= 1'b1;
            if (state_q == S_DATA) begin
                unique case (lane_q)
                    W_TWO:   rx_byte <= {rx_byte[5:0], io_i[1:0]};
                    W_FOUR:  rx_byte <= {rx_byte[3:0], io_i};
                    default: rx_byte <= {rx_byte[6:0], io_i[1]};
                endcase
            end
        end else if (fall) begin
            sck <= 1'b0;
            if (cnt_q != 5'd0) begin
                cnt_q <= cnt_q - 1'b1;
                sh_q  <= {sh_q[ADDR_W-2:0], 1'b0};
            end else begin
                unique case (state_q)
                    S_OPC: begin
                        sh_q  <= four_q ? adr_q : {adr_q[23:0], 8'h00};
                        cnt_q <= four_q ? 5'd31 : 5'd23;
                    end
                    S_ADDR:  cnt_q <= dummy_q ? 5'(DUMMY_CLK - 1) : data_cnt;
                    S_DUMMY: cnt_q <= data_cnt;
                    default: cs_n  <= 1'b1;
                endcase
            end
        end
    end

    assign run   = (state_q != S_IDLE) && (state_q != S_FINISH);
    assign done  = (state_q == S_FINISH);
    assign io_o  = {3'b000, sh_q[ADDR_W-1]};
    assign io_oe = ((state_q == S_OPC) || (state_q == S_ADDR)) ? 4'b0001 : 4'b0000;

    // R10: serial clock rests low while the flash is deselected
    assert_sck_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);
    // R3: only IO0 is ever driven, and only with the flash selected
    assert_io_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe != 4'b0000) |-> (io_oe == 4'b0001 && !cs_n));
endmodule

// File: rtl/nor_byte_reader.sv
module nor_byte_reader
    import nbr_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [3:0] reg_waddr,
    input  logic [7:0] reg_wdata,
    input  logic [3:0] reg_raddr,
    output logic [7:0] reg_rdata,
    output logic       flash_cs_n,
    output logic       flash_sck,
    output logic [3:0] flash_io_o,
    output logic [3:0] flash_io_oe,
    input  logic [3:0] flash_io_i
);
    logic        start, busy, done, run, tick, fast, four_byte;
    logic [7:0]  opcode, rx_byte;
    logic [ADDR_W-1:0] addr;
    lane_t       lane;

    nbr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr),
        .wdata(reg_wdata), .raddr(reg_raddr), .rdata(reg_rdata),
        .done(done), .rx_byte(rx_byte), .start(start), .busy(busy),
        .opcode(opcode), .addr(addr), .lane(lane), .fast(fast),
        .four_byte(four_byte)
    );

    nbr_tick #(.HALF(SCK_HALF)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    nbr_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
        .opcode(opcode), .addr(addr), .lane(lane), .fast(fast),
        .four_byte(four_byte), .io_i(flash_io_i), .run(run),
        .cs_n(flash_cs_n), .sck(flash_sck), .io_o(flash_io_o),
        .io_oe(flash_io_oe), .rx_byte(rx_byte), .done(done)
    );

    // R2: the flash is selected only while the command is busy
    assert_cs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_cs_n |-> busy);
    // R8: start bits are clear on the edge after chip select rises
    assert_busy_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_cs_n) |=> !busy);
endmodule

// File: tb/tb_nor_byte_reader.sv
module tb_nor_byte_reader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_waddr = '0;
    logic [7:0] reg_wdata = '0;
    logic [3:0] reg_raddr = '0;
    logic [7:0] reg_rdata;
    logic       flash_cs_n, flash_sck;
    logic [3:0] flash_io_o, flash_io_oe;
    logic [3:0] flash_io_i = '0;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    nor_byte_reader dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .flash_cs_n(flash_cs_n), .flash_sck(flash_sck), .flash_io_o(flash_io_o),
        .flash_io_oe(flash_io_oe), .flash_io_i(flash_io_i)
    );

    // flash model settings, written by the bench before each read
    int         m_abits = 24;
    int         m_dummy = 0;
    int         m_width = 1;
    logic [7:0] m_byte  = '0;
    int         pos_cnt = 0;
    logic [7:0] rx_op = '0;
    logic [31:0] rx_addr = '0;

    always @(negedge flash_cs_n) begin
        pos_cnt = 0;
        rx_op   = '0;
        rx_addr = '0;
    end

    always @(posedge flash_sck) begin
        if (!flash_cs_n) begin
            if (pos_cnt < 8)
                rx_op = {rx_op[6:0], flash_io_o[0]};
            else if (pos_cnt < 8 + m_abits)
                rx_addr = {rx_addr[30:0], flash_io_o[0]};
            pos_cnt = pos_cnt + 1;
        end
    end

    always @(negedge flash_sck) begin
        int pre;
        int k;
        logic [7:0] t;
        pre = 8 + m_abits + m_dummy;
        if (!flash_cs_n && pos_cnt >= pre) begin
            k = pos_cnt - pre;
            if (k < 8 / m_width) begin
                t = m_byte << (m_width * k);
                if (m_width == 1)      flash_io_i = {2'b00, t[7], 1'b0};
                else if (m_width == 2) flash_io_i = {2'b00, t[7:6]};
                else                   flash_io_i = t[7:4];
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] c;
        int n;
        n = 0;
        do begin
            @(negedge clk);
            rd(4'd0, c);
            n++;
        end while (c[4:0] != 5'd0 && n < 5000);
    endtask

    task automatic setup(input logic [7:0] op, input logic [7:0] mode,
                         input logic f, input logic fb, input logic [31:0] a);
        wr(4'd1, a[7:0]);
        wr(4'd2, a[15:8]);
        wr(4'd3, a[23:16]);
        wr(4'd4, a[31:24]);
        wr(4'd5, op);
        wr(4'd6, mode);
        wr(4'd7, {6'b0, fb, f});
        m_abits = fb ? 32 : 24;
        m_width = (mode == 8'h01) ? 2 : (mode == 8'h04) ? 4 : 1;
        m_dummy = (f || mode != 8'h00) ? 8 : 0;
        m_byte  = a[7:0] ^ op ^ 8'h3C;
    endtask

    // {opcode, mode, fast, four_byte, address}
    localparam logic [49:0] VEC [6] = '{
        {8'h03, 8'h00, 1'b0, 1'b0, 32'h0012_3456},
        {8'h0B, 8'h00, 1'b1, 1'b0, 32'h00AB_CDEF},
        {8'h3B, 8'h01, 1'b0, 1'b0, 32'h7755_AA33},
        {8'h6B, 8'h04, 1'b0, 1'b0, 32'h00F0_E1D2},
        {8'h13, 8'h00, 1'b0, 1'b1, 32'h89AB_CDEF},
        {8'h6C, 8'h04, 1'b0, 1'b1, 32'hDEAD_BEEF}
    };

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "cs_n", {31'b0, flash_cs_n}, 32'd1);
        check("R1", "sck", {31'b0, flash_sck}, 32'd0);
        check("R1", "io_oe", {28'b0, flash_io_oe}, 32'd0);
        rd(4'd0, v); check("R1", "cmd", {24'b0, v}, 32'h00);
        rd(4'd8, v); check("R1", "rdata", {24'b0, v}, 32'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 6; i++) begin
            logic [31:0] exp_a;
            setup(VEC[i][49:42], VEC[i][41:34], VEC[i][33], VEC[i][32], VEC[i][31:0]);
            wr(4'd0, 8'h81);
            rd(4'd0, v); check("R2", "cmd while busy", {24'b0, v}, 32'h81);
            wait_idle();
            exp_a = VEC[i][32] ? VEC[i][31:0] : {8'h00, VEC[i][23:0]};
            check("R3", "opcode seen", {24'b0, rx_op}, {24'b0, VEC[i][49:42]});
            check("R4", "address seen", rx_addr, exp_a);
            check("R5_R6", "sck clock count", pos_cnt,
                  8 + m_abits + m_dummy + 8 / m_width);
            rd(4'd8, v); check("R7", "read data", {24'b0, v}, {24'b0, m_byte});
            rd(4'd0, v); check("R2", "cmd after done", {24'b0, v}, 32'h80);
        end

        // R2: a non-start code while idle does nothing
        wr(4'd0, 8'h12);
        repeat (20) @(negedge clk);
        check("R2", "cs_n after bad code", {31'b0, flash_cs_n}, 32'd1);
        rd(4'd0, v); check("R2", "cmd after bad code", {24'b0, v}, 32'h80);

        // R9: command writes during a read are ignored
        setup(8'h0B, 8'h01, 1'b1, 1'b0, 32'h0001_0203);
        wr(4'd0, 8'h81);
        repeat (30) @(negedge clk);
        wr(4'd0, 8'h00);
        wr(4'd0, 8'h81);
        rd(4'd0, v); check("R9", "cmd unchanged", {24'b0, v}, 32'h81);
        check("R9", "still selected", {31'b0, flash_cs_n}, 32'd0);
        wait_idle();
        rd(4'd8, v); check("R9", "read data", {24'b0, v}, {24'b0, m_byte});
        check("R9", "single transfer clocks", pos_cnt, 8 + 24 + 8 + 4);

        // R8: start bits clear one system clock after chip select rises
        setup(8'h03, 8'h04, 1'b0, 1'b0, 32'h0000_0055);
        wr(4'd0, 8'h81);
        reg_raddr = 4'd0;
        while (flash_cs_n) @(negedge clk);
        while (!flash_cs_n) @(negedge clk);
        #1;
        check("R8", "busy at cs rise", {31'b0, |reg_rdata[4:0]}, 32'd1);
        @(negedge clk);
        #1;
        check("R8", "busy one clock later", {31'b0, |reg_rdata[4:0]}, 32'd0);
        check("R10", "sck low when deselected", {31'b0, flash_sck}, 32'd0);
        rd(4'd8, v); check("R6", "quad plain data", {24'b0, v}, {24'b0, m_byte});

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule